// File: doc/BRIEF.md
# Random Number Generator Control and Status Registers

This block is the register front end of a hardware random number generator. Software reaches it through a plain register port with an address, a write strobe, a read strobe and 32-bit data in each direction. Behind the registers it keeps two timed operations, seeding and self-test. Each operation has its own idle/running/done state. The running state shows up as live bits in the command register, and the done state shows up as sticky bits in the status register.

A single level interrupt reports that an operation has finished. A mask bit can hold it back, and a clear command drops it. A software reset command returns the operations and the control bits to their idle values. The data register is fed by a 32-bit xorshift generator that stands in for the entropy source, so a system can be brought up and its driver exercised without real noise hardware.

Top module: `rngen_csr`

## Requirements
- R1: The registers sit at these offsets: 0x00 identity, 0x04 command, 0x08 control, 0x0C status and 0x14 data. Any other offset reads as zero, and a write to it changes nothing. A write to identity, status or data also changes nothing.
- R2: The identity register always reads 0x1000_0240. That is type 1 in bits 31:28, major revision 2 in bits 15:8 and minor revision 0x40 in bits 7:0.
- R3: Writing command bit 1 starts seeding, and writing command bit 0 starts self-test. A started operation is running for exactly RUN_CYCLES clock cycles after the write edge and then becomes done. Done stays until the operation is started again or reset.
- R4: Reading the command register returns bit 1 while seeding runs and bit 0 while self-test runs. All other bits read as zero.
- R5: Control bit 6 (error mask), bit 5 (done-interrupt mask) and bit 4 (auto-seed) are replaced as a group by each control write and read back as written. All other control bits read as zero.
- R6: Status bits 15:12 read 5, bits 11:8 read 5 and bit 6 reads 1. Bit 5 is set while seeding is done, and bit 4 is set while self-test is done. Bits 31:16, 7, 3 and 2 read 0.
- R7: `irq` rises on the edge where an operation becomes done, unless control bit 5 is set at that moment. A command write with bit 4 or bit 5 set lowers `irq`. A completion on the same edge as such a clear wins, and `irq` is then high.
- R8: A command write with bit 6 set returns both operations to idle and clears the three control bits. A start bit in the same write then takes effect. `irq` is not changed by it. Hardware reset does the same and also lowers `irq`.
- R9: The data register shows the current word of a xorshift generator (x^=x<<13, x^=x>>17, x^=x<<5) loaded with SEED at hardware reset. The generator advances by one step only on a read strobe at offset 0x14. Software reset leaves it alone.
- R10: Status bit 1 (busy) is set while either operation runs. Otherwise status bit 0 (ready) is set. The two are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; advances the generator when it hits the data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq | output | 1 | Level completion interrupt |

## Verification
The assertions take for granted that a write strobe lasts one cycle per access. They also assume the address is stable during a strobe and that no accesses happen until the internal reset has been released. The bench drives every access from the falling clock edge, holds each strobe for exactly one cycle, and leaves the port idle for several cycles after each reset release. A behavioural model with plain integers follows each register and each operation's countdown, and its expected read data and interrupt are compared with the design on every cycle. Directed steps then aim at the exact completion edge, at a clear that lands on that edge, and at software reset combined with a start.

// File: rtl/rngen_pkg.sv
package rngen_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RUN  = 2'd1,
    OP_DONE = 2'd2
  } op_state_e;

  localparam int OFF_IDENT  = 'h00;
  localparam int OFF_CMD    = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_STATUS = 'h0C;
  localparam int OFF_DATA   = 'h14;

  localparam int NUM_OPS  = 2;
  localparam int OP_SEED  = 0;
  localparam int OP_TEST  = 1;

  localparam int CMD_SRST     = 6;
  localparam int CMD_CLR_ERR  = 5;
  localparam int CMD_CLR_IRQ  = 4;
  localparam int CMD_SEED     = 1;
  localparam int CMD_TEST     = 0;

  localparam int CTL_MASK_ERR  = 6;
  localparam int CTL_MASK_DONE = 5;
  localparam int CTL_AUTO_SEED = 4;

  localparam logic [31:0] IDENT_WORD  = 32'h1000_0240;
  localparam logic [3:0]  FIFO_DEPTH  = 4'd5;

endpackage

// File: rtl/rngen_rst_sync.sv
module rngen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rngen_op_tracker.sv
module rngen_op_tracker
  import rngen_pkg::*;
#(
  parameter int RUN_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_rst,
  input  logic      start,
  output op_state_e state,
  output logic      done
);

  localparam int CNT_W = (RUN_CYCLES > 1) ? $clog2(RUN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_CYCLES - 1);

  op_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             finish;

  assign finish = (state_q == OP_RUN) && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    if (soft_rst) begin
      state_d = OP_IDLE;
      cnt_d   = '0;
    end
    if (start) begin
      state_d = OP_RUN;
      cnt_d   = '0;
    end else if (!soft_rst && finish) begin
      state_d = OP_DONE;
      cnt_d   = '0;
      done    = 1'b1;
    end else if (!soft_rst && state_q == OP_RUN) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = soft_rst | start | (state_q == OP_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OP_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/rngen_xorshift.sv
module rngen_xorshift #(
  parameter logic [31:0] SEED = 32'h2545_F491
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  output logic [31:0] word
);

  logic [31:0] x_q, x_d;
  logic [31:0] s1, s2;

  always_comb begin
    s1  = x_q ^ (x_q << 13);
    s2  = s1 ^ (s1 >> 17);
    x_d = s2 ^ (s2 << 5);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= SEED;
    end else if (advance) begin
      x_q <= x_d;
    end
  end

  assign word = x_q;

endmodule

// File: rtl/rngen_csr.sv
module rngen_csr
  import rngen_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          RUN_CYCLES = 16,
  parameter logic [31:0] SEED       = 32'h2545_F491
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  logic rst_sync_n;

  rngen_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address decode
  logic hit_ident, hit_cmd, hit_ctrl, hit_status, hit_data;
  assign hit_ident  = (bus_addr == ADDR_W'(OFF_IDENT));
  assign hit_cmd    = (bus_addr == ADDR_W'(OFF_CMD));
  assign hit_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_status = (bus_addr == ADDR_W'(OFF_STATUS));
  assign hit_data   = (bus_addr == ADDR_W'(OFF_DATA));

  logic cmd_wr, ctrl_wr, soft_rst, clr_irq;
  logic [NUM_OPS-1:0] op_start;
  assign cmd_wr   = bus_wr & hit_cmd;
  assign ctrl_wr  = bus_wr & hit_ctrl;
  assign soft_rst = cmd_wr & bus_wdata[CMD_SRST];
  assign clr_irq  = cmd_wr & (bus_wdata[CMD_CLR_ERR] | bus_wdata[CMD_CLR_IRQ]);
  assign op_start[OP_SEED] = cmd_wr & bus_wdata[CMD_SEED];
  assign op_start[OP_TEST] = cmd_wr & bus_wdata[CMD_TEST];

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:7], bus_wdata[3:2]};

  // operation trackers
  op_state_e          op_state [NUM_OPS];
  logic [NUM_OPS-1:0] op_done;
  logic [NUM_OPS-1:0] op_running;
  logic [NUM_OPS-1:0] op_finished;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    rngen_op_tracker #(
      .RUN_CYCLES (RUN_CYCLES)
    ) u_trk (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .soft_rst (soft_rst),
      .start    (op_start[g]),
      .state    (op_state[g]),
      .done     (op_done[g])
    );
    assign op_running[g]  = (op_state[g] == OP_RUN);
    assign op_finished[g] = (op_state[g] == OP_DONE);
  end

  // control register
  logic mask_err, mask_done, auto_seed;
  logic mask_err_d, mask_done_d, auto_seed_d;
  logic ctrl_en;

  always_comb begin
    mask_err_d  = mask_err;
    mask_done_d = mask_done;
    auto_seed_d = auto_seed;
    if (soft_rst) begin
      mask_err_d  = 1'b0;
      mask_done_d = 1'b0;
      auto_seed_d = 1'b0;
    end else if (ctrl_wr) begin
      mask_err_d  = bus_wdata[CTL_MASK_ERR];
      mask_done_d = bus_wdata[CTL_MASK_DONE];
      auto_seed_d = bus_wdata[CTL_AUTO_SEED];
    end
  end

  assign ctrl_en = soft_rst | ctrl_wr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mask_err  <= 1'b0;
      mask_done <= 1'b0;
      auto_seed <= 1'b0;
    end else if (ctrl_en) begin
      mask_err  <= mask_err_d;
      mask_done <= mask_done_d;
      auto_seed <= auto_seed_d;
    end
  end

  // interrupt
  logic irq_q, irq_d, irq_set, irq_en;
  assign irq_set = (|op_done) & ~mask_done;

  always_comb begin
    irq_d = irq_q;
    if (clr_irq) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  assign irq_en = irq_set | clr_irq;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // random source
  logic [31:0] rng_word;
  logic        rng_adv;
  assign rng_adv = bus_rd & hit_data;

  rngen_xorshift #(
    .SEED (SEED)
  ) u_rng (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .advance (rng_adv),
    .word    (rng_word)
  );

  // read mux
  logic        busy;
  logic [31:0] status_word, cmd_word, ctrl_word;

  assign busy = |op_running;

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_SEED] = op_running[OP_SEED];
    cmd_word[CMD_TEST] = op_running[OP_TEST];

    ctrl_word = '0;
    ctrl_word[CTL_MASK_ERR]  = mask_err;
    ctrl_word[CTL_MASK_DONE] = mask_done;
    ctrl_word[CTL_AUTO_SEED] = auto_seed;

    status_word        = '0;
    status_word[15:12] = FIFO_DEPTH;
    status_word[11:8]  = FIFO_DEPTH;
    status_word[6]     = 1'b1;
    status_word[5]     = op_finished[OP_SEED];
    status_word[4]     = op_finished[OP_TEST];
    status_word[1]     = busy;
    status_word[0]     = ~busy;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ident)  bus_rdata = IDENT_WORD;
    if (hit_cmd)    bus_rdata = cmd_word;
    if (hit_ctrl)   bus_rdata = ctrl_word;
    if (hit_status) bus_rdata = status_word;
    if (hit_data)   bus_rdata = rng_word;
  end

endmodule

// File: rtl/rngen_csr_sva.sv
module rngen_csr_sva
  import rngen_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic [1:0]        seed_st,
  input logic [1:0]        test_st,
  input logic [1:0]        op_done,
  input logic              mask_done,
  input logic [31:0]       rng_word
);

  logic cmd_wr, ctrl_wr;
  assign cmd_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD));
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));

  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seed_st == 2'(OP_DONE) && $past(seed_st) != 2'(OP_DONE)) |-> $past(seed_st) == 2'(OP_RUN)); // R3

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> $past((|op_done) && !mask_done)); // R7

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && (bus_wdata[5] || bus_wdata[4]) && op_done == 2'b00) |=> !irq); // R7

  AST_SRST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_wr && bus_wdata[6] && bus_wdata[1:0] == 2'b00) |=> (seed_st == 2'(OP_IDLE) && test_st == 2'(OP_IDLE) && !mask_done)); // R8

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_wr && !(cmd_wr && bus_wdata[6])) |=> $stable(mask_done)); // R5

  AST_RNG_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_rd && bus_addr == ADDR_W'(OFF_DATA)) |=> $stable(rng_word)); // R9

  AST_BUSY_XOR_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == ADDR_W'(OFF_STATUS)) |-> (bus_rdata[1] != bus_rdata[0])); // R10

endmodule

bind rngen_csr rngen_csr_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .seed_st    (op_state[0]),
  .test_st    (op_state[1]),
  .op_done    (op_done),
  .mask_done  (mask_done),
  .rng_word   (rng_word)
);

// File: tb/test_rngen_csr.sv
module test_rngen_csr;

  localparam int          N    = 16;
  localparam logic [31:0] SEED = 32'h2545_F491;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  rngen_csr #(.ADDR_W(12), .RUN_CYCLES(N), .SEED(SEED)) i_rngen_csr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_st [2];
  int          m_cnt[2];
  bit          m_me, m_md, m_as, m_irq;
  logic [31:0] m_x;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_me = 0; m_md = 0; m_as = 0; m_irq = 0; m_x = SEED;
    end else begin
      bit cw, sr, cl, any_done;
      bit st[2];
      cw = bus_wr && bus_addr == 12'h004;
      sr = cw && bus_wdata[6];
      cl = cw && (bus_wdata[5] || bus_wdata[4]);
      st[0] = cw && bus_wdata[1];
      st[1] = cw && bus_wdata[0];
      any_done = 0;
      for (int i = 0; i < 2; i++) begin
        if (sr) begin m_st[i] = 0; m_cnt[i] = 0; end
        if (st[i]) begin
          m_st[i] = 1; m_cnt[i] = 0;
        end else if (m_st[i] == 1) begin
          if (m_cnt[i] == N - 1) begin m_st[i] = 2; any_done = 1; end
          else m_cnt[i]++;
        end
      end
      if (any_done && !m_md) m_irq = 1;
      else if (cl) m_irq = 0;
      if (sr) begin m_me = 0; m_md = 0; m_as = 0; end
      else if (bus_wr && bus_addr == 12'h008) begin
        m_me = bus_wdata[6]; m_md = bus_wdata[5]; m_as = bus_wdata[4];
      end
      if (bus_rd && bus_addr == 12'h014) m_x = xs(m_x);
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a, output string req);
    logic [31:0] v;
    bit run;
    v = '0; req = "R1";
    run = (m_st[0] == 1) || (m_st[1] == 1);
    case (a)
      12'h000: begin v = 32'h1000_0240; req = "R2"; end
      12'h004: begin v = {30'd0, m_st[0] == 1, m_st[1] == 1}; req = "R4"; end
      12'h008: begin v = {25'd0, m_me, m_md, m_as, 4'd0}; req = "R5"; end
      12'h00C: begin
        v = 32'h0000_5540 | (m_st[0] == 2 ? 32'h20 : 0) | (m_st[1] == 2 ? 32'h10 : 0)
            | (run ? 32'h2 : 32'h1);
        req = "R6";
      end
      12'h014: begin v = m_x; req = "R9"; end
      default: v = '0;
    endcase
    return v;
  endfunction

  int quiet = 4;
  always @(negedge clk) begin
    #2;
    if (!rst_n) quiet = 4;
    else if (quiet > 0) quiet--;
    else if (!finished) begin
      string rq;
      logic [31:0] e;
      e = m_read(bus_addr, rq);
      chk(rq, "model rdata", bus_rdata, e);
      chk("R7", "model irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #3;
    v = bus_rdata;
  endtask

  task automatic pop(output logic [31:0] v);
    bus_addr = 12'h014; bus_rd = 1'b1;
    #3;
    v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, x;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // reset state
    peek(12'h00C, v); chk("R6", "status after reset", v, 32'h0000_5541);
    peek(12'h004, v); chk("R4", "command after reset", v, 0);
    peek(12'h008, v); chk("R5", "control after reset", v, 0);
    chk("R7", "irq after reset", {31'd0, irq}, 0);
    peek(12'h000, v); chk("R2", "identity", v, 32'h1000_0240);

    // unmapped and read-only offsets
    peek(12'h010, v); chk("R1", "unmapped read", v, 0);
    peek(12'hFFC, v); chk("R1", "high unmapped read", v, 0);
    wr_reg(12'h00C, 32'hFFFF_FFFF);
    wr_reg(12'h010, 32'hFFFF_FFFF);
    peek(12'h004, v); chk("R1", "command after stray writes", v, 0);
    peek(12'h008, v); chk("R1", "control after stray writes", v, 0);

    // control read-back
    wr_reg(12'h008, 32'hFFFF_FFFF);
    peek(12'h008, v); chk("R5", "control all ones", v, 32'h70);
    wr_reg(12'h008, 32'h0000_0020);
    peek(12'h008, v); chk("R5", "control replace", v, 32'h20);
    wr_reg(12'h008, 0);

    // seeding, exact completion edge
    wr_reg(12'h004, 32'h2);
    peek(12'h004, v); chk("R4", "seed running", v, 32'h2);
    peek(12'h00C, v); chk("R10", "busy while seeding", v, 32'h0000_5542);
    idle(N - 1);
    peek(12'h00C, v); chk("R3", "still running at N-1", v, 32'h0000_5542);
    chk("R7", "irq low before done", {31'd0, irq}, 0);
    idle(1);
    peek(12'h00C, v); chk("R3", "seed done at N", v, 32'h0000_5561);
    chk("R7", "irq on completion", {31'd0, irq}, 1);
    peek(12'h004, v); chk("R4", "command idle after done", v, 0);
    wr_reg(12'h004, 32'h10);
    chk("R7", "clear interrupt", {31'd0, irq}, 0);

    // masked self-test
    wr_reg(12'h008, 32'h20);
    wr_reg(12'h004, 32'h1);
    peek(12'h004, v); chk("R4", "self-test running", v, 32'h1);
    idle(N);
    peek(12'h00C, v); chk("R6", "both done bits", v, 32'h0000_5571);
    chk("R7", "masked completion", {31'd0, irq}, 0);

    // both at once, clear-error lowers
    wr_reg(12'h008, 0);
    wr_reg(12'h004, 32'h3);
    peek(12'h00C, v); chk("R10", "busy both", v, 32'h0000_5542);
    idle(N);
    chk("R7", "irq after both", {31'd0, irq}, 1);
    wr_reg(12'h004, 32'h20);
    chk("R7", "clear-error lowers irq", {31'd0, irq}, 0);

    // clear on the completion edge
    wr_reg(12'h004, 32'h2);
    idle(N - 1);
    wr_reg(12'h004, 32'h10);
    chk("R7", "completion beats clear", {31'd0, irq}, 1);

    // software reset keeps irq, clears state
    wr_reg(12'h008, 32'h70);
    wr_reg(12'h004, 32'h40);
    chk("R8", "irq kept by soft reset", {31'd0, irq}, 1);
    peek(12'h00C, v); chk("R8", "status after soft reset", v, 32'h0000_5541);
    peek(12'h008, v); chk("R8", "control after soft reset", v, 0);
    wr_reg(12'h004, 32'h10);
    wr_reg(12'h008, 32'h50);
    wr_reg(12'h004, 32'h42);
    peek(12'h004, v); chk("R8", "reset then start", v, 32'h2);
    peek(12'h008, v); chk("R8", "control cleared by combined write", v, 0);
    idle(N + 1);

    // random data
    x = SEED;
    for (int k = 0; k < 3; k++) begin
      pop(v); chk("R9", "data word", v, x);
      x = xs(x);
    end
    idle(2);
    peek(12'h014, v); chk("R9", "no advance without strobe", v, x);
    wr_reg(12'h004, 32'h40);
    peek(12'h014, v); chk("R9", "soft reset keeps generator", v, x);
    pop(v);

    // hardware reset in mid-run
    wr_reg(12'h004, 32'h3);
    idle(3);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(5);
    peek(12'h00C, v); chk("R8", "status after hardware reset", v, 32'h0000_5541);
    chk("R8", "irq after hardware reset", {31'd0, irq}, 0);
    peek(12'h014, v); chk("R9", "generator reloaded", v, SEED);

    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule